// File: doc/BRIEF.md
# Host Bridge Window Decode Register File

This block is the CPU-facing register file of a processor-to-PCI host bridge. It answers 32-bit word accesses inside a 4 KB aperture over a plain strobe-based bus. It holds the address windows the CPU uses to reach two PCI buses: one I/O window and two memory windows per bus, each with a low-decode field, a high-decode field and a remap field. It also holds a CPU configuration word, two PCI command words and a PCI configuration-address word.

Accesses to the configuration-data word are not stored. They go straight out on a side port to the configuration engine. A read of the interrupt-acknowledge word returns the vector currently offered by the interrupt controller. From the first bus's I/O window the block continuously produces a base address and a length, and it pulses a strobe whenever a write may have changed the window mapping. Registers with no function read as zero and ignore writes.

Top module: `hb_decode_regs`

## Requirements
- R1: The word index is taken from address bits [11:2], so address bits above bit 11 and bits [1:0] are ignored. The byte offsets used are: CPU configuration 0x000; the low/high/remap offsets per window (first-bus I/O, first-bus memory 0, first-bus memory 1, second-bus I/O, second-bus memory 0, second-bus memory 1) are 0x048/0x050/0x0F0, 0x058/0x060/0x0F8, 0x080/0x088/0x100, 0x090/0x098/0x108, 0x0A0/0x0A8/0x110 and 0x0B0/0x0B8/0x118; command words 0xC00 and 0xC80; configuration address 0xCF8; configuration data 0xCFC; interrupt acknowledge 0xC34.
- R2: A write to a low-decode offset stores the data masked with 0x7FFF. In the same access it stores the data masked with 0x7FF into the remap register of that window.
- R3: A write to a high-decode offset stores the data masked with 0x7F. A direct write to a remap offset stores the data masked with 0x7FF and leaves the low-decode register unchanged.
- R4: A write to either command word stores the data masked with 0x0401FC0F. A write to the CPU configuration word stores all 32 bits.
- R5: A write to the configuration-address word stores the data masked with 0x80FFFFFC. That value reads back unchanged and is driven on `cfg_addr`.
- R6: A write to the configuration-data offset raises `cfgd_wr` in the same cycle, with `cfgd_wdata` equal to the write data. A read of that offset raises `cfgd_rd` in the same cycle and returns `cfgd_rdata` as sampled in that cycle.
- R7: Every offset not listed in R1, including the error-report, ECC and multi-processor words, ignores writes and reads as zero.
- R8: `io_base` (36 bits) equals the first-bus I/O low-decode register shifted left by 21.
- R9: `io_len` (36 bits) equals ((high + 1 - (low AND 0x7F)) modulo 2^15) shifted left by 21, where low and high are the first-bus I/O decode registers.
- R10: After reset the low/high pairs are 0x80/0x0F, 0x90/0x1F, 0x790/0x1F, 0x100/0x0F, 0x110/0x1F and 0x120/0x2F in R1 window order. Each remap register equals its low value. The configuration-address word is zero.
- R11: With `LITTLE_END`=1 (the default) the CPU configuration word resets to 0x800 and both command words reset to 0x00010001. With `LITTLE_END`=0 all three reset to zero.
- R12: A read of the interrupt-acknowledge offset returns `irq_vec` as sampled in the read cycle.
- R13: `rd_data` and `rd_valid` are registered and appear one cycle after `acc_rd`. A read and a write to the same offset in one cycle return the value held before the write.
- R14: `map_upd` is high for exactly the one cycle after any write to a low-decode, high-decode, remap or CPU configuration offset. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after acc_rd |
| cfgd_wr | output | 1 | Configuration-data write forwarded |
| cfgd_rd | output | 1 | Configuration-data read forwarded |
| cfgd_wdata | output | 32 | Forwarded configuration write data |
| cfgd_rdata | input | 32 | Configuration read data from the engine |
| cfg_addr | output | 32 | Stored configuration address |
| irq_vec | input | 32 | Interrupt vector from the interrupt controller |
| io_base | output | 36 | I/O window base address |
| io_len | output | 36 | I/O window length |
| map_upd | output | 1 | Mapping recomputed pulse |

## Verification
A read and a write can land in the same cycle on the same offset. The read must return the old value, while the write lands and, for decode offsets, also raises `map_upd` one cycle later. The bench drives both strobes together on low-decode, remap and command offsets. It then checks that the returned word equals the model's value from before the write, and that a second read shows the masked new value. Random streams mix writes and reads over all mapped offsets and over aliased, error and unused addresses, and the bench checks every result against a bench-side model.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  localparam int NWIN   = 6;
  localparam int IDX_W  = 10;
  localparam int LO_W   = 15;
  localparam int HI_W   = 7;
  localparam int RM_W   = 11;
  localparam int SHIFT  = 21;
  localparam int WIN_AW = LO_W + SHIFT;

  typedef logic [IDX_W-1:0] widx_t;

  localparam logic [31:0] CMD_MASK  = 32'h0401_FC0F;
  localparam logic [31:0] CFGA_MASK = 32'h80FF_FFFC;

  localparam widx_t IDX_CPU   = widx_t'(12'h000 >> 2);
  localparam widx_t IDX_CMD0  = widx_t'(12'hC00 >> 2);
  localparam widx_t IDX_CMD1  = widx_t'(12'hC80 >> 2);
  localparam widx_t IDX_CFGA  = widx_t'(12'hCF8 >> 2);
  localparam widx_t IDX_CFGD  = widx_t'(12'hCFC >> 2);
  localparam widx_t IDX_IACK  = widx_t'(12'hC34 >> 2);

  function automatic widx_t lo_idx(input int w);
    case (w)
      0: lo_idx = widx_t'(12'h048 >> 2);
      1: lo_idx = widx_t'(12'h058 >> 2);
      2: lo_idx = widx_t'(12'h080 >> 2);
      3: lo_idx = widx_t'(12'h090 >> 2);
      4: lo_idx = widx_t'(12'h0A0 >> 2);
      default: lo_idx = widx_t'(12'h0B0 >> 2);
    endcase
  endfunction

  function automatic widx_t hi_idx(input int w);
    hi_idx = lo_idx(w) + widx_t'(2);
  endfunction

  function automatic widx_t rm_idx(input int w);
    rm_idx = widx_t'((12'h0F0 >> 2) + 2 * w);
  endfunction

  function automatic logic [LO_W-1:0] lo_rst(input int w);
    case (w)
      0: lo_rst = LO_W'(12'h080);
      1: lo_rst = LO_W'(12'h090);
      2: lo_rst = LO_W'(12'h790);
      3: lo_rst = LO_W'(12'h100);
      4: lo_rst = LO_W'(12'h110);
      default: lo_rst = LO_W'(12'h120);
    endcase
  endfunction

  function automatic logic [HI_W-1:0] hi_rst(input int w);
    case (w)
      0, 3: hi_rst = HI_W'(8'h0F);
      5:    hi_rst = HI_W'(8'h2F);
      default: hi_rst = HI_W'(8'h1F);
    endcase
  endfunction

endpackage

// File: rtl/hbd_window_bank.sv
module hbd_window_bank
  import hbd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  widx_t                      wr_idx,
  input  logic [31:0]                wr_data,
  output logic [NWIN-1:0][LO_W-1:0]  lo_q,
  output logic [NWIN-1:0][HI_W-1:0]  hi_q,
  output logic [NWIN-1:0][RM_W-1:0]  rm_q,
  output logic                       win_hit
);

  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [LO_W-1:0] lo_r, lo_d;
    logic [HI_W-1:0] hi_r, hi_d;
    logic [RM_W-1:0] rm_r, rm_d;
    logic            lo_en, hi_en, rm_en;

    always_comb begin
      lo_d  = wr_data[LO_W-1:0];
      hi_d  = wr_data[HI_W-1:0];
      rm_d  = wr_data[RM_W-1:0];
      lo_en = wr_en && (wr_idx == lo_idx(w));
      hi_en = wr_en && (wr_idx == hi_idx(w));
      // a low-decode write also rewrites the paired remap field
      rm_en = lo_en || (wr_en && (wr_idx == rm_idx(w)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_r <= lo_rst(w);
        hi_r <= hi_rst(w);
        rm_r <= RM_W'(lo_rst(w));
      end else begin
        if (lo_en) lo_r <= lo_d;
        if (hi_en) hi_r <= hi_d;
        if (rm_en) rm_r <= rm_d;
      end
    end

    assign lo_q[w] = lo_r;
    assign hi_q[w] = hi_r;
    assign rm_q[w] = rm_r;
    assign hit[w]  = lo_en | hi_en | rm_en;
  end

  assign win_hit = |hit;

endmodule

// File: rtl/hbd_ctrl_regs.sv
module hbd_ctrl_regs
  import hbd_pkg::*;
#(
  parameter bit LITTLE_END = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  widx_t       wr_idx,
  input  logic [31:0] wr_data,
  output logic [31:0] cpu_q,
  output logic [31:0] cmd0_q,
  output logic [31:0] cmd1_q,
  output logic [31:0] cfga_q,
  output logic        cpu_hit
);

  localparam logic [31:0] CPU_RST = LITTLE_END ? 32'h0000_0800 : 32'h0;
  localparam logic [31:0] CMD_RST = LITTLE_END ? 32'h0001_0001 : 32'h0;

  logic        cmd0_en, cmd1_en, cfga_en;
  logic [31:0] cmd_d, cfga_d;

  always_comb begin
    cpu_hit = wr_en && (wr_idx == IDX_CPU);
    cmd0_en = wr_en && (wr_idx == IDX_CMD0);
    cmd1_en = wr_en && (wr_idx == IDX_CMD1);
    cfga_en = wr_en && (wr_idx == IDX_CFGA);
    cmd_d   = wr_data & CMD_MASK;
    cfga_d  = wr_data & CFGA_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q  <= CPU_RST;
      cmd0_q <= CMD_RST;
      cmd1_q <= CMD_RST;
      cfga_q <= 32'h0;
    end else begin
      if (cpu_hit) cpu_q  <= wr_data;
      if (cmd0_en) cmd0_q <= cmd_d;
      if (cmd1_en) cmd1_q <= cmd_d;
      if (cfga_en) cfga_q <= cfga_d;
    end
  end

endmodule

// File: rtl/hbd_io_map.sv
module hbd_io_map
  import hbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   lo,
  input  logic [HI_W-1:0]   hi,
  input  logic              upd_req,
  output logic [WIN_AW-1:0] io_base,
  output logic [WIN_AW-1:0] io_len,
  output logic              map_upd
);

  logic [LO_W-1:0] span;

  always_comb begin
    span    = LO_W'(hi) + LO_W'(1) - LO_W'(lo & LO_W'(7'h7F));
    io_base = {lo, {SHIFT{1'b0}}};
    io_len  = {span, {SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_upd <= 1'b0;
    else        map_upd <= upd_req;
  end

endmodule

// File: rtl/hbd_read_port.sv
module hbd_read_port
  import hbd_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  widx_t                      rd_idx,
  input  logic [NWIN-1:0][LO_W-1:0]  lo_q,
  input  logic [NWIN-1:0][HI_W-1:0]  hi_q,
  input  logic [NWIN-1:0][RM_W-1:0]  rm_q,
  input  logic [31:0]                cpu_q,
  input  logic [31:0]                cmd0_q,
  input  logic [31:0]                cmd1_q,
  input  logic [31:0]                cfga_q,
  input  logic [31:0]                cfgd_rdata,
  input  logic [31:0]                irq_vec,
  output logic [31:0]                rd_data,
  output logic                       rd_valid
);

  logic [31:0] sel;

  always_comb begin
    sel = 32'h0;
    for (int w = 0; w < NWIN; w++) begin
      if (rd_idx == lo_idx(w)) sel = 32'(lo_q[w]);
      if (rd_idx == hi_idx(w)) sel = 32'(hi_q[w]);
      if (rd_idx == rm_idx(w)) sel = 32'(rm_q[w]);
    end
    case (rd_idx)
      IDX_CPU:  sel = cpu_q;
      IDX_CMD0: sel = cmd0_q;
      IDX_CMD1: sel = cmd1_q;
      IDX_CFGA: sel = cfga_q;
      IDX_CFGD: sel = cfgd_rdata;
      IDX_IACK: sel = irq_vec;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 32'h0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

endmodule

// File: rtl/hb_decode_regs.sv
module hb_decode_regs
  import hbd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit LITTLE_END = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              cfgd_wr,
  output logic              cfgd_rd,
  output logic [31:0]       cfgd_wdata,
  input  logic [31:0]       cfgd_rdata,
  output logic [31:0]       cfg_addr,
  input  logic [31:0]       irq_vec,
  output logic [WIN_AW-1:0] io_base,
  output logic [WIN_AW-1:0] io_len,
  output logic              map_upd
);

  widx_t                      idx;
  logic [NWIN-1:0][LO_W-1:0]  lo_q;
  logic [NWIN-1:0][HI_W-1:0]  hi_q;
  logic [NWIN-1:0][RM_W-1:0]  rm_q;
  logic                       win_hit, cpu_hit;
  logic [31:0]                cpu_q, cmd0_q, cmd1_q;

  assign idx        = acc_addr[IDX_W+1:2];
  assign cfgd_wr    = acc_wr && (idx == IDX_CFGD);
  assign cfgd_rd    = acc_rd && (idx == IDX_CFGD);
  assign cfgd_wdata = acc_wdata;

  hbd_window_bank u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .wr_idx(idx), .wr_data(acc_wdata),
    .lo_q(lo_q), .hi_q(hi_q), .rm_q(rm_q), .win_hit(win_hit)
  );

  hbd_ctrl_regs #(.LITTLE_END(LITTLE_END)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .wr_idx(idx), .wr_data(acc_wdata),
    .cpu_q(cpu_q), .cmd0_q(cmd0_q), .cmd1_q(cmd1_q), .cfga_q(cfg_addr),
    .cpu_hit(cpu_hit)
  );

  hbd_io_map u_map (
    .clk(clk), .rst_n(rst_n), .lo(lo_q[0]), .hi(hi_q[0]),
    .upd_req(win_hit | cpu_hit),
    .io_base(io_base), .io_len(io_len), .map_upd(map_upd)
  );

  hbd_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_rd), .rd_idx(idx),
    .lo_q(lo_q), .hi_q(hi_q), .rm_q(rm_q),
    .cpu_q(cpu_q), .cmd0_q(cmd0_q), .cmd1_q(cmd1_q), .cfga_q(cfg_addr),
    .cfgd_rdata(cfgd_rdata), .irq_vec(irq_vec),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
  import hbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              rd_valid,
  input logic              cfgd_wr,
  input logic [31:0]       cfg_addr,
  input logic [WIN_AW-1:0] io_base,
  input logic              map_upd
);

  logic [11:0] boff;
  logic        map_wr;

  always_comb begin
    boff   = {acc_addr[11:2], 2'b00};
    map_wr = acc_wr && ((boff == 12'h000) ||
             ((boff >= 12'h048) && (boff <= 12'h0B8) && (boff[2:0] == 3'b000)
              && (boff != 12'h068) && (boff != 12'h070) && (boff != 12'h078)) ||
             ((boff >= 12'h0F0) && (boff <= 12'h118) && (boff[2:0] == 3'b000)));
  end

  p_rd_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);

  p_no_spurious_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rd_valid);

  p_map_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> map_upd);

  p_map_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> !map_upd);

  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(io_base));

  p_cfgd_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfgd_wr |-> (acc_wr && (boff == 12'hCFC)));

  p_cfga_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr & ~CFGA_MASK) == 32'h0);

endmodule

bind hb_decode_regs hbd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
  .rd_valid(rd_valid), .cfgd_wr(cfgd_wr), .cfg_addr(cfg_addr),
  .io_base(io_base), .map_upd(map_upd)
);

// File: tb/sim_hb_decode_regs.sv
module sim_hb_decode_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic [31:0] rd_data, cfgd_wdata, cfg_addr;
  logic        rd_valid, cfgd_wr, cfgd_rd, map_upd;
  logic [31:0] cfgd_rdata = '0, irq_vec = '0;
  logic [35:0] io_base, io_len;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_decode_regs u0 (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .cfgd_wr(cfgd_wr), .cfgd_rd(cfgd_rd), .cfgd_wdata(cfgd_wdata),
    .cfgd_rdata(cfgd_rdata), .cfg_addr(cfg_addr), .irq_vec(irq_vec),
    .io_base(io_base), .io_len(io_len), .map_upd(map_upd)
  );

  // bench model
  logic [14:0] m_lo [6];
  logic [6:0]  m_hi [6];
  logic [10:0] m_rm [6];
  logic [31:0] m_cpu, m_cmd0, m_cmd1, m_cfga;

  function automatic [11:0] off_lo(input int w);
    case (w) 0: return 12'h048; 1: return 12'h058; 2: return 12'h080;
             3: return 12'h090; 4: return 12'h0A0; default: return 12'h0B0; endcase
  endfunction
  function automatic [11:0] off_hi(input int w); return off_lo(w) + 12'h8; endfunction
  function automatic [11:0] off_rm(input int w); return 12'h0F0 + 12'(8 * w); endfunction

  function automatic [31:0] exp_read(input [31:0] a);
    logic [11:0] b = {a[11:2], 2'b00};
    for (int w = 0; w < 6; w++) begin
      if (b == off_lo(w)) return 32'(m_lo[w]);
      if (b == off_hi(w)) return 32'(m_hi[w]);
      if (b == off_rm(w)) return 32'(m_rm[w]);
    end
    case (b)
      12'h000: return m_cpu;
      12'hC00: return m_cmd0;
      12'hC80: return m_cmd1;
      12'hCF8: return m_cfga;
      12'hCFC: return cfgd_rdata;
      12'hC34: return irq_vec;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_map(input [31:0] a);
    logic [11:0] b = {a[11:2], 2'b00};
    if (b == 12'h000) return 1;
    for (int w = 0; w < 6; w++)
      if (b == off_lo(w) || b == off_hi(w) || b == off_rm(w)) return 1;
    return 0;
  endfunction

  task automatic model_write(input [31:0] a, input [31:0] d);
    logic [11:0] b = {a[11:2], 2'b00};
    for (int w = 0; w < 6; w++) begin
      if (b == off_lo(w)) begin m_lo[w] = d[14:0]; m_rm[w] = d[10:0]; end
      if (b == off_hi(w)) m_hi[w] = d[6:0];
      if (b == off_rm(w)) m_rm[w] = d[10:0];
    end
    case (b)
      12'h000: m_cpu  = d;
      12'hC00: m_cmd0 = d & 32'h0401FC0F;
      12'hC80: m_cmd1 = d & 32'h0401FC0F;
      12'hCF8: m_cfga = d & 32'h80FFFFFC;
      default: ;
    endcase
  endtask

  function automatic [35:0] exp_base(); return {m_lo[0], 21'b0}; endfunction
  function automatic [35:0] exp_len();
    logic [14:0] s = 15'(m_hi[0]) + 15'd1 - (m_lo[0] & 15'h7F);
    return {s, 21'b0};
  endfunction

  task automatic chk(input string req, input [63:0] act, input [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input [31:0] a, input [31:0] d, input string req);
    bit mp = is_map(a);
    @(negedge clk);
    acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 0;
    model_write(a, d);
    chk({req, " map_upd"}, 64'(map_upd), 64'(mp));
    chk({req, " io_base"}, 64'(io_base), 64'(exp_base()));
    chk({req, " io_len"},  64'(io_len),  64'(exp_len()));
  endtask

  task automatic do_read(input [31:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    acc_rd = 1; acc_addr = a;
    e = exp_read(a);
    @(negedge clk);
    acc_rd = 0;
    chk({req, " rd_valid"}, 64'(rd_valid), 64'd1);
    chk({req, " rd_data"},  64'(rd_data),  64'(e));
  endtask

  // read and write in the same cycle: old value returned
  task automatic do_rw(input [31:0] a, input [31:0] d, input string req);
    logic [31:0] e;
    @(negedge clk);
    acc_rd = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    e = exp_read(a);
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
    model_write(a, d);
    chk({req, " old value"}, 64'(rd_data), 64'(e));
    chk({req, " map_upd"}, 64'(map_upd), 64'(is_map(a)));
  endtask

  function automatic [31:0] pick_addr(input int k, input [31:0] r);
    logic [31:0] hi = {r[31:12], 12'h0};
    case (k % 26)
      0: return hi | 32'h000;  1: return hi | 32'hC00;  2: return hi | 32'hC80;
      3: return hi | 32'hCF8;  4: return hi | 32'h120;  5: return hi | 32'h070;
      6: return hi | 32'h138;  7: return hi | 32'h480;  8: return hi | 32'h490;
      9: return hi | 32'hC34; 10: return hi | {20'h0, r[11:2], 2'b00};
      11, 12, 13, 14, 15, 16: return hi | 32'(off_lo(k % 26 - 11));
      17, 18, 19, 20, 21, 22: return hi | 32'(off_hi(k % 26 - 17));
      default: return hi | 32'(off_rm(k % 6));
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_lo = '{15'h080, 15'h090, 15'h790, 15'h100, 15'h110, 15'h120};
    m_hi = '{7'h0F, 7'h1F, 7'h1F, 7'h0F, 7'h1F, 7'h2F};
    for (int w = 0; w < 6; w++) m_rm[w] = m_lo[w][10:0];
    m_cpu = 32'h800; m_cmd0 = 32'h00010001; m_cmd1 = 32'h00010001; m_cfga = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 R11 reset state, R8 R9 derived outputs
    chk("R8 reset base", 64'(io_base), 64'(36'h0_1000_0000));
    chk("R9 reset len",  64'(io_len),  64'(36'h0_0200_0000));
    chk("R14 idle map_upd", 64'(map_upd), 64'd0);
    for (int w = 0; w < 6; w++) begin
      do_read(32'(off_lo(w)), "R10 reset lo");
      do_read(32'(off_hi(w)), "R10 reset hi");
      do_read(32'(off_rm(w)), "R10 reset remap");
    end
    do_read(32'h000, "R11 reset cpu");
    do_read(32'hC00, "R11 reset cmd0");
    do_read(32'hC80, "R11 reset cmd1");
    do_read(32'hCF8, "R10 reset cfgaddr");
    // R2 low write with remap side effect, aliased address R1
    do_write(32'hABCD_5048, 32'hFFFF_FFFF, "R2 lo write alias R1");
    do_read(32'h048, "R2 lo masked");
    do_read(32'h0F0, "R2 remap copy");
    // R3 direct remap does not touch lo
    do_write(32'h0F0, 32'h1234_5555, "R3 remap write");
    do_read(32'h0F0, "R3 remap masked");
    do_read(32'h048, "R3 lo untouched");
    do_write(32'h050, 32'hFFFF_FF80, "R3 hi write");
    do_read(32'h050, "R3 hi masked");
    // R9 wrap case: low field above high+1
    do_write(32'h048, 32'h0000_007F, "R9 wrap lo");
    do_write(32'h050, 32'h0000_0000, "R9 wrap hi");
    chk("R9 wrap len", 64'(io_len), 64'({15'h7F82, 21'b0}));
    // R4 R5
    do_write(32'hC00, 32'hFFFF_FFFF, "R4 cmd0");
    do_read(32'hC00, "R4 cmd0 masked");
    do_write(32'h000, 32'hDEAD_BEEF, "R4 cpu full R14");
    do_read(32'h000, "R4 cpu");
    do_write(32'hCF8, 32'hFFFF_FFFF, "R5 cfgaddr");
    chk("R5 cfg_addr port", 64'(cfg_addr), 64'(32'h80FF_FFFC));
    do_read(32'hCF8, "R5 cfgaddr readback");
    // R6 configuration data pass-through
    @(negedge clk);
    acc_wr = 1; acc_addr = 32'hCFC; acc_wdata = 32'h5A5A_1234;
    #1;
    chk("R6 cfgd_wr", 64'(cfgd_wr), 64'd1);
    chk("R6 cfgd_wdata", 64'(cfgd_wdata), 64'(32'h5A5A_1234));
    @(negedge clk);
    acc_wr = 0;
    chk("R6 no map_upd", 64'(map_upd), 64'd0);
    cfgd_rdata = 32'hC0FF_EE01;
    @(negedge clk);
    acc_rd = 1; acc_addr = 32'hCFC;
    #1;
    chk("R6 cfgd_rd", 64'(cfgd_rd), 64'd1);
    @(negedge clk);
    acc_rd = 0;
    chk("R6 cfgd read data", 64'(rd_data), 64'(32'hC0FF_EE01));
    // R12 interrupt acknowledge
    irq_vec = 32'h0000_002A;
    do_read(32'hC34, "R12 iack");
    // R7 ignored registers
    do_write(32'h070, 32'hFFFF_FFFF, "R7 err write");
    do_read(32'h070, "R7 err reads zero");
    do_write(32'h488, 32'hFFFF_FFFF, "R7 ecc write");
    do_read(32'h488, "R7 ecc reads zero");
    do_write(32'h120, 32'hFFFF_FFFF, "R7 multi write");
    do_read(32'h120, "R7 multi reads zero");
    // R13 simultaneous read and write
    do_rw(32'h058, 32'h0000_4321, "R13 rw lo");
    do_read(32'h058, "R13 after rw");
    do_rw(32'hC80, 32'hFFFF_FFFF, "R13 rw cmd1");
    do_read(32'hC80, "R13 after rw cmd1");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom();
      logic [31:0] a = pick_addr(int'($urandom() % 26), r);
      logic [31:0] d = $urandom();
      irq_vec = $urandom(); cfgd_rdata = $urandom();
      case ($urandom() % 3)
        0: do_write(a, d, "R2 random write");
        1: do_read(a, "R1 random read");
        default: do_rw(a, d, "R13 random rw");
      endcase
    end
    // R14 quiet after non-map write
    do_write(32'hC00, 32'h0, "R14 cmd no pulse");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule